// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Address Sequencer

This block sits on the processor side of an interrupt system. Each cycle it compares a 3-bit pending request level with the current priority mask. When it takes a request, it raises the mask to that level. It then runs a read on a simple bus-master interface, using function code 3'b111 to mark processor space. The responder ends that read in one of two ways:

- It returns a vector number together with a data-size acknowledge (`busDsack`).
- It asserts the autovector terminate (`busAvec`). The vector number then comes from the level.

The block then builds a 32-bit vector-table address by concatenation with the upper part of the vector base register. It presents that address with a one-cycle done strobe.

The table has 256 entries. Interrupts can use 199 of them: 192 user vectors returned by devices (numbers 64 to 255) and 7 autovectors, one per level (numbers 25 to 31). The base register and the mask are loaded from the surrounding processor through plain load inputs. Restoring the mask after a service routine uses the same mask load input.

Top module: `irq_vector_fetch`

## Requirements
- R1: After a synchronous reset the mask reads 7, the base register is zero, `busStrobe` and `vecDone` are low, and no acknowledge starts until a request is taken.
- R2: In idle, a level L from 1 to 6 is taken only when L > mask. On the edge that takes it, the mask becomes L and the acknowledge read starts (`busStrobe` high one cycle later). A level that is lower than or equal to the mask starts nothing and leaves the mask unchanged.
- R3: Level 7 is non-maskable. It is taken when it is above the mask, or when the mask is 7 but the level input changed to 7 from another value on the previous cycle. A level 7 held steady does not start a second acknowledge.
- R4: While `busStrobe` is high, `busFc` is 3'b111 and `busAddr` is {20 ones, L, 1'b1}: the level sits on address bits 3:1 and bit 0 is 1. These outputs stay fixed for any number of wait cycles until a terminate is seen. Outside the read, `busFc` and `busAddr` are zero.
- R5: A read ended by `busDsack` with `busAvec` low takes the 8-bit `busData` as the vector number.
- R6: A read ended by `busAvec` uses vector number 24+L. `busAvec` wins when both terminates are high.
- R7: One cycle after the terminating edge, `vecDone` is high for exactly one cycle. `vecAddr` equals {base[31:10], vector, 2'b00} and holds until the next completion. `busStrobe` is low in that same cycle.
- R8: `vbrLoad` writes `vbrHiData` into base bits 31:10. `maskLoad` writes `maskData` into the mask, except on an edge where a request is taken, when the taken level wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqLevel | input | 3 | Pending request level, 0 = none |
| vbrLoad | input | 1 | Load the base register |
| vbrHiData | input | 22 | New base register bits 31:10 |
| maskLoad | input | 1 | Load the priority mask |
| maskData | input | 3 | New mask value |
| busStrobe | output | 1 | Acknowledge read in progress |
| busFc | output | 3 | Function code, 3'b111 during the read |
| busAddr | output | 24 | Read address |
| busData | input | 8 | Vector number from the responder |
| busDsack | input | 1 | Terminate with supplied vector |
| busAvec | input | 1 | Terminate with autovector |
| ipMask | output | 3 | Current priority mask |
| vecAddr | output | 32 | Formed vector-table address |
| vecDone | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach from the ports is the level-7 corner. The mask is already 7, so taking the request depends only on whether the level has just changed to 7, and holding it steady must not start a second read. The bench sweeps every mask against every level from an input of 0, so each first arrival of 7 is a change. A separate step leaves level 7 asserted across and after a completion and watches that the strobe stays low. A further step moves the level from 6 to 7 with the mask at 7 to show the change need not come from 0. The sweep also rotates the terminate style per case: supplied vector, autovector, and both terminates together. This reaches the precedence of the autovector over the supplied vector.

// File: rtl/irqvf_pkg.sv
package irqvf_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_ACK = 1'b1} seqState_t;

  typedef struct packed {
    logic takeIrq;   // latch level, raise mask
    logic endUser;   // read ended with supplied vector
    logic endAuto;   // read ended with autovector
  } seqStrobe_t;

  localparam logic [2:0] FC_PROC_SPACE = 3'b111;
endpackage

// File: rtl/irqvf_ctrl.sv
module irqvf_ctrl
  import irqvf_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic [LVL_W-1:0] ipMask,
  input  logic             busDsack,
  input  logic             busAvec,
  output seqStrobe_t       strobes,
  output logic             busStrobe,
  output logic             vecDone
);
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  seqState_t        state;
  logic [LVL_W-1:0] lastLvl;
  logic             reqValid;
  logic             nmiEdge;

  always_comb begin
    nmiEdge  = (irqLevel == TOP_LVL) && (lastLvl != TOP_LVL);
    reqValid = (irqLevel != '0) && ((irqLevel > ipMask) || nmiEdge);
    strobes.takeIrq = (state == ST_IDLE) && reqValid;
    strobes.endAuto = (state == ST_ACK) && busAvec;
    strobes.endUser = (state == ST_ACK) && busDsack && !busAvec;
  end

  assign busStrobe = (state == ST_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      lastLvl <= '0;
      vecDone <= 1'b0;
    end else begin
      lastLvl <= irqLevel;
      vecDone <= strobes.endUser || strobes.endAuto;
      case (state)
        ST_IDLE: if (strobes.takeIrq) state <= ST_ACK;
        ST_ACK:  if (strobes.endUser || strobes.endAuto) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqvf_dpath.sv
module irqvf_dpath
  import irqvf_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 24,
  parameter int VA_W      = 32,
  parameter int AUTO_BASE = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  seqStrobe_t              strobes,
  input  logic                    busStrobe,
  input  logic [LVL_W-1:0]        irqLevel,
  input  logic                    vbrLoad,
  input  logic [VA_W-VEC_W-3:0]   vbrHiData,
  input  logic                    maskLoad,
  input  logic [LVL_W-1:0]        maskData,
  input  logic [VEC_W-1:0]        busData,
  output logic [LVL_W-1:0]        ipMask,
  output logic [2:0]              busFc,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [VA_W-1:0]         vecAddr
);
  localparam int HI_W  = VA_W - VEC_W - 2;
  localparam int PAD_W = ADDR_W - LVL_W - 1;

  logic [HI_W-1:0]  vbrHi;
  logic [LVL_W-1:0] curLvl;
  logic [VEC_W-1:0] vecNum;

  always_comb begin
    if (strobes.endAuto) vecNum = VEC_W'(AUTO_BASE) + VEC_W'(curLvl);
    else                 vecNum = busData;
  end

  assign busFc   = busStrobe ? FC_PROC_SPACE : 3'b000;
  assign busAddr = busStrobe ? {{PAD_W{1'b1}}, curLvl, 1'b1} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ipMask  <= '1;
      vbrHi   <= '0;
      curLvl  <= '0;
      vecAddr <= '0;
    end else begin
      if (strobes.takeIrq) begin
        ipMask <= irqLevel;
        curLvl <= irqLevel;
      end else if (maskLoad) begin
        ipMask <= maskData;
      end
      if (vbrLoad) vbrHi <= vbrHiData;
      if (strobes.endUser || strobes.endAuto)
        vecAddr <= {vbrHi, vecNum, 2'b00};
    end
  end
endmodule

// File: rtl/irq_vector_fetch.sv
module irq_vector_fetch
  import irqvf_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 24,
  parameter int VA_W      = 32,
  parameter int AUTO_BASE = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LVL_W-1:0]      irqLevel,
  input  logic                  vbrLoad,
  input  logic [VA_W-VEC_W-3:0] vbrHiData,
  input  logic                  maskLoad,
  input  logic [LVL_W-1:0]      maskData,
  output logic                  busStrobe,
  output logic [2:0]            busFc,
  output logic [ADDR_W-1:0]     busAddr,
  input  logic [VEC_W-1:0]      busData,
  input  logic                  busDsack,
  input  logic                  busAvec,
  output logic [LVL_W-1:0]      ipMask,
  output logic [VA_W-1:0]       vecAddr,
  output logic                  vecDone
);
  seqStrobe_t strobes;

  irqvf_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst), .irqLevel(irqLevel), .ipMask(ipMask),
    .busDsack(busDsack), .busAvec(busAvec), .strobes(strobes),
    .busStrobe(busStrobe), .vecDone(vecDone)
  );

  irqvf_dpath #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
    .VA_W(VA_W), .AUTO_BASE(AUTO_BASE)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobes(strobes), .busStrobe(busStrobe),
    .irqLevel(irqLevel), .vbrLoad(vbrLoad), .vbrHiData(vbrHiData),
    .maskLoad(maskLoad), .maskData(maskData), .busData(busData),
    .ipMask(ipMask), .busFc(busFc), .busAddr(busAddr), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/irqvf_checker.sv
module irqvf_checker (
  input logic        clk,
  input logic        rst,
  input logic        busStrobe,
  input logic [2:0]  busFc,
  input logic [23:0] busAddr,
  input logic [7:0]  busData,
  input logic        busDsack,
  input logic        busAvec,
  input logic [2:0]  ipMask,
  input logic [31:0] vecAddr,
  input logic        vecDone
);
  // R2: mask equals the level being acknowledged when the read starts
  a_r2_mask_raised: assert property (@(posedge clk) disable iff (rst)
    $rose(busStrobe) |-> ipMask == busAddr[3:1]);

  // R4: processor-space code and address during the read
  a_r4_proc_space: assert property (@(posedge clk) disable iff (rst)
    busStrobe |-> (busFc == 3'b111 && busAddr[23:4] == 20'hFFFFF && busAddr[0]));

  // R4: read stays put until a terminate is seen
  a_r4_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (busStrobe && !busDsack && !busAvec) |=> (busStrobe && $stable(busAddr)));

  // R5: supplied vector lands in the address
  a_r5_user_vec: assert property (@(posedge clk) disable iff (rst)
    (busStrobe && busDsack && !busAvec) |=> (vecDone && vecAddr[9:2] == $past(busData)));

  // R6: autovector derived from level
  a_r6_auto_vec: assert property (@(posedge clk) disable iff (rst)
    (busStrobe && busAvec) |=> (vecDone && vecAddr[9:2] == 8'(24 + $past(busAddr[3:1]))));

  // R7: done is a single-cycle pulse after a read, with the bus released
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    vecDone |-> (!busStrobe && $past(busStrobe)) ##1 !vecDone);

  // R7: address low bits are zero on completion
  a_r7_low_zero: assert property (@(posedge clk) disable iff (rst)
    vecDone |-> vecAddr[1:0] == 2'b00);
endmodule

bind irq_vector_fetch irqvf_checker u_chk (
  .clk(clk), .rst(rst), .busStrobe(busStrobe), .busFc(busFc),
  .busAddr(busAddr), .busData(busData), .busDsack(busDsack),
  .busAvec(busAvec), .ipMask(ipMask), .vecAddr(vecAddr), .vecDone(vecDone)
);

// File: tb/tb_irq_vector_fetch.sv
module tb_irq_vector_fetch;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  irqLevel;
  logic        vbrLoad;
  logic [21:0] vbrHiData;
  logic        maskLoad;
  logic [2:0]  maskData;
  logic        busStrobe;
  logic [2:0]  busFc;
  logic [23:0] busAddr;
  logic [7:0]  busData;
  logic        busDsack;
  logic        busAvec;
  logic [2:0]  ipMask;
  logic [31:0] vecAddr;
  logic        vecDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_vector_fetch dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] expAddr;
    logic [7:0]  vec;
    logic [21:0] hi;
    rst = 1; irqLevel = 0; vbrLoad = 0; vbrHiData = 0; maskLoad = 0;
    maskData = 0; busData = 0; busDsack = 0; busAvec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    check("R1 mask", {29'd0, ipMask}, 32'd7);
    check("R1 strobe", {31'd0, busStrobe}, 0);
    check("R1 done", {31'd0, vecDone}, 0);
    check("R1 fc", {29'd0, busFc}, 0);
    irqLevel = 3'd6;                                // below reset mask 7
    @(negedge clk);
    check("R1 no start", {31'd0, busStrobe}, 0);
    irqLevel = 0;
    @(negedge clk);

    for (int m = 0; m < 8; m++) begin
      for (int l = 1; l < 8; l++) begin
        hi = 22'h2A5C3 ^ 22'(m * 4099 + l * 131);
        maskLoad = 1; maskData = 3'(m); vbrLoad = 1; vbrHiData = hi; irqLevel = 0;
        @(negedge clk);
        maskLoad = 0; vbrLoad = 0;
        check("R8 mask load", {29'd0, ipMask}, 32'(m));
        irqLevel = 3'(l);
        @(negedge clk);
        if (l > m || l == 7) begin
          // R2/R3 taken
          check(l == 7 ? "R3 nmi taken" : "R2 taken", {31'd0, busStrobe}, 1);
          check("R2 mask raised", {29'd0, ipMask}, 32'(l));
          check("R4 fc", {29'd0, busFc}, 32'd7);
          check("R4 addr", {8'd0, busAddr}, {8'd0, 20'hFFFFF, 3'(l), 1'b1});
          irqLevel = 0;
          repeat ((m + l) % 3) begin
            @(negedge clk);
            check("R4 wait hold", {8'd0, busStrobe, busAddr[22:0]}, {8'd0, 1'b1, 19'h7FFFF, 3'(l), 1'b1});
          end
          busData = 8'(64 + m * 23 + l * 7);
          case ((m + l) % 3)
            0: begin busDsack = 1; vec = busData; end
            1: begin busAvec = 1; vec = 8'(24 + l); end
            default: begin busDsack = 1; busAvec = 1; vec = 8'(24 + l); end
          endcase
          expAddr = {hi, vec, 2'b00};
          @(negedge clk);
          busDsack = 0; busAvec = 0;
          check("R7 done", {31'd0, vecDone}, 1);
          check(((m + l) % 3 == 0) ? "R5 user vector" : "R6 autovector", vecAddr, expAddr);
          check("R7 strobe off", {31'd0, busStrobe}, 0);
          @(negedge clk);
          check("R7 single pulse", {31'd0, vecDone}, 0);
          check("R7 addr held", vecAddr, expAddr);
        end else begin
          check("R2 held off", {31'd0, busStrobe}, 0);
          check("R2 mask kept", {29'd0, ipMask}, 32'(m));
          irqLevel = 0;
          @(negedge clk);
        end
      end
    end

    // R3: level 7 held steady with mask 7 does not retrigger
    maskLoad = 1; maskData = 7; irqLevel = 0;
    @(negedge clk);
    maskLoad = 0; irqLevel = 7;
    @(negedge clk);
    check("R3 first 7 taken", {31'd0, busStrobe}, 1);
    busAvec = 1;
    @(negedge clk);
    busAvec = 0;
    check("R3 done", {31'd0, vecDone}, 1);
    repeat (4) begin
      @(negedge clk);
      check("R3 held 7 no retrigger", {31'd0, busStrobe}, 0);
    end
    irqLevel = 6;
    @(negedge clk);
    check("R3 six under mask", {31'd0, busStrobe}, 0);
    irqLevel = 7;
    @(negedge clk);
    check("R3 6 to 7 taken", {31'd0, busStrobe}, 1);
    // R8: mask load on a taking edge loses to the level
    busDsack = 1; busData = 8'hC8; irqLevel = 0;
    @(negedge clk);
    busDsack = 0;
    maskLoad = 1; maskData = 2;
    @(negedge clk);
    maskLoad = 0;
    check("R8 mask load", {29'd0, ipMask}, 2);
    maskLoad = 1; maskData = 1; irqLevel = 5;
    @(negedge clk);
    maskLoad = 0; irqLevel = 0;
    check("R8 take wins", {29'd0, ipMask}, 5);
    busDsack = 1;
    @(negedge clk);
    busDsack = 0;
    @(negedge clk);
    finish_run();
  end
endmodule